// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block is one channel of a direct memory access engine. Software loads a source address, a destination address, a transfer count and a control word, then pulses a start input. The channel then copies that many items, one at a time, from the source to the destination. It uses two independent single-beat master ports: one issues reads, the other issues writes. Each item is a byte, a halfword or a word. After each item either address may step forward, may stay fixed (for a peripheral data register), or may wrap inside a power-of-two ring. Bytes can be reversed inside the item before it is written. Each item can be held back until a selected peripheral request line is high.

The channel is built around one state machine. ST_IDLE waits for a start while the reload count is nonzero. It then moves to ST_WAIT_REQ, which waits until the channel is enabled and the selected request line is high (or pacing is off). From there the machine goes to ST_RD_ADDR, which holds the read request until it is accepted. ST_RD_DATA waits for the read response; an error response sends it back to ST_IDLE, otherwise it moves on to ST_WR_ADDR. ST_WR_ADDR holds the write request until it is accepted. ST_WR_RESP waits for the write response. From ST_WR_RESP the machine returns to ST_WAIT_REQ for the next item, or to ST_IDLE after the last item or after an error.

The configuration port is a plain synchronous write strobe with an address, and a combinational read port. Register index 0 is the read address, 1 the write address, 2 the count, and 3 the control/status word.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset the control word reads 0x0001F81D: enable=1 (bit 0), size=2 (bits 2:1), read increment=1 (bit 3), write increment=1 (bit 4), ring bits=0 (bits 8:5), ring select=0 (bit 9), byte reversal=0 (bit 10), request select=63 (bits 16:11). Both addresses and the count read 0, and busy is 0.
- R2: A start pulse while idle with a nonzero count reload loads the remaining count, and busy (busy_o and control bit 31) is high from the next cycle. The remaining count (register 2) drops by one after each successful write response. Busy falls after the last write response.
- R3: Size 0, 1 and 2 move 1, 2 and 4 bytes per item (3 behaves as 4). The read address steps by the item width only when bit 3 is set, and the write address only when bit 4 is set.
- R4: With ring bits N nonzero, stepping the selected address changes only its low N bits, so it wraps inside an aligned 2^N-byte window. N=0 means no wrapping.
- R5: Ring select 0 applies the ring to the read address and 1 applies it to the write address; the other address steps normally.
- R6: Writing register 2 sets the reload for the next start and does not change the remaining count of a running sequence.
- R7: With bit 10 set, the byte order inside a halfword or word item is reversed before the write; byte items are unchanged.
- R8: The item is taken from the read-data lanes selected by the low read-address bits. It is written on the lanes starting at the low write-address bits, with wr_req_strb_o marking exactly those lanes (1, 2 or 4 bits).
- R9: When the request select is not 63, no read is issued until request line dreq_i[select] is high in ST_WAIT_REQ. Each high cycle there releases one item, and other lines have no effect. Select 63 runs unpaced.
- R10: Clearing enable (bit 0) holds the channel in ST_WAIT_REQ with busy high and the addresses and count kept; setting it again resumes.
- R11: A read error response sets bit 29, and a write error response sets bit 30. Either one stops the channel (busy falls) without stepping the addresses or count. Bit 28 is their OR. Writing 1 to bit 29 or 30 clears that flag; writing 0 leaves it.
- R12: A start pulse while busy, or while the count reload is 0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_waddr_i | input | 2 | Register write index |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_raddr_i | input | 2 | Register read index |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| start_i | input | 1 | Start pulse |
| dreq_i | input | NREQ | Peripheral transfer request lines |
| busy_o | output | 1 | Sequence in progress |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | 32 | Read byte address |
| rd_req_size_o | output | 2 | Read item size code |
| rd_resp_valid_i | input | 1 | Read response valid |
| rd_resp_data_i | input | 32 | Read response word |
| rd_resp_err_i | input | 1 | Read response error |
| wr_req_valid_o | output | 1 | Write request valid |
| wr_req_ready_i | input | 1 | Write request accepted |
| wr_req_addr_o | output | 32 | Write byte address |
| wr_req_data_o | output | 32 | Write data on byte lanes |
| wr_req_strb_o | output | 4 | Write byte strobes |
| wr_resp_valid_i | input | 1 | Write response valid |
| wr_resp_err_i | input | 1 | Write response error |

## Verification
The copy function is run with word, halfword and byte items at unaligned lane offsets. It is also run with each address held fixed in turn, with the ring applied first to the read side and then to the write side, and with reversal on halfwords and words. Comparing the written lanes and the final addresses separates an error in the step width from an error in the lane shift. A ready signal that toggles every cycle shows whether the request is held until it is accepted. Pacing tests drive the unselected request lines high while the selected line stays low, then give a single-cycle pulse, so the bench can tell a line-select error apart from an edge/level error. The error tests show that the two flags stay separate, that clearing by writing 1 works, and that nothing steps when a response fails.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int RING_W  = 4;
    localparam int SEL_W   = 6;
    localparam logic [SEL_W-1:0] SEL_FREE = '1;

    localparam logic [1:0] REG_RADDR = 2'd0;
    localparam logic [1:0] REG_WADDR = 2'd1;
    localparam logic [1:0] REG_COUNT = 2'd2;
    localparam logic [1:0] REG_CTRL  = 2'd3;

    localparam int BIT_BUSY   = 31;
    localparam int BIT_WR_ERR = 30;
    localparam int BIT_RD_ERR = 29;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_REQ = 3'd1,
        ST_RD_ADDR  = 3'd2,
        ST_RD_DATA  = 3'd3,
        ST_WR_ADDR  = 3'd4,
        ST_WR_RESP  = 3'd5
    } chan_state_e;

    typedef struct packed {
        logic [SEL_W-1:0]  req_sel;
        logic              bswap;
        logic              ring_sel;
        logic [RING_W-1:0] ring_bits;
        logic              inc_wr;
        logic              inc_rd;
        logic [1:0]        size;
        logic              en;
    } chan_ctrl_t;

    localparam int CTRL_W = $bits(chan_ctrl_t);

    localparam chan_ctrl_t CTRL_RESET = '{
        req_sel:   SEL_FREE,
        bswap:     1'b0,
        ring_sel:  1'b0,
        ring_bits: '0,
        inc_wr:    1'b1,
        inc_rd:    1'b1,
        size:      2'd2,
        en:        1'b1
    };

    function automatic logic [2:0] step_bytes(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_xfer_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              inc_i,
    input  logic              ring_on_i,
    input  logic [RING_W-1:0] ring_bits_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] low_mask;

    // R3 / R4: step by item width, keep upper bits when the ring is active
    always_comb begin
        sum      = addr_i + ADDR_W'(step_bytes(size_i));
        low_mask = (ADDR_W'(1) << ring_bits_i) - ADDR_W'(1);
        if (!inc_i) begin
            addr_o = addr_i;
        end else if (ring_on_i && (ring_bits_i != '0)) begin
            addr_o = (addr_i & ~low_mask) | (sum & low_mask);
        end else begin
            addr_o = sum;
        end
    end

endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack
    import dma_xfer_pkg::*;
(
    input  logic [DATA_W-1:0] rd_word_i,
    input  logic [1:0]        rd_off_i,
    input  logic [1:0]        wr_off_i,
    input  logic [1:0]        size_i,
    input  logic              bswap_i,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [LANES-1:0]  wr_strb_o
);

    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] word_rev;
    logic [DATA_W-1:0] item;
    logic [LANES-1:0]  base;

    assign aligned = rd_word_i >> {rd_off_i, 3'b000};

    // R7: full-word byte reversal built lane by lane
    for (genvar k = 0; k < LANES; k++) begin : g_rev
        assign word_rev[8*k +: 8] = aligned[8*(LANES-1-k) +: 8];
    end

    // R8: extract from read lanes, place on write lanes with strobes
    always_comb begin
        item = '0;
        base = '0;
        unique case (size_i)
            2'd0: begin
                item[7:0] = aligned[7:0];
                base      = LANES'(4'b0001);
            end
            2'd1: begin
                item[15:0] = bswap_i ? {aligned[7:0], aligned[15:8]} : aligned[15:0];
                base       = LANES'(4'b0011);
            end
            default: begin
                item = bswap_i ? word_rev : aligned;
                base = '1;
            end
        endcase
        wr_data_o = item << {wr_off_i, 3'b000};
        wr_strb_o = base << wr_off_i;
    end

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        go_i,
    input  logic        last_i,
    input  logic        rd_req_ready_i,
    input  logic        rd_resp_valid_i,
    input  logic        rd_resp_err_i,
    input  logic        wr_req_ready_i,
    input  logic        wr_resp_valid_i,
    input  logic        wr_resp_err_i,
    output chan_state_e state_o,
    output logic        busy_o,
    output logic        load_o,
    output logic        rd_valid_o,
    output logic        latch_o,
    output logic        rd_fault_o,
    output logic        wr_valid_o,
    output logic        step_done_o,
    output logic        wr_fault_o
);

    chan_state_e state_q;
    chan_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_WAIT_REQ;
            ST_WAIT_REQ: if (go_i) state_d = ST_RD_ADDR;
            ST_RD_ADDR:  if (rd_req_ready_i) state_d = ST_RD_DATA;
            ST_RD_DATA:  if (rd_resp_valid_i) state_d = rd_resp_err_i ? ST_IDLE : ST_WR_ADDR;
            ST_WR_ADDR:  if (wr_req_ready_i) state_d = ST_WR_RESP;
            ST_WR_RESP:  if (wr_resp_valid_i)
                             state_d = (wr_resp_err_i || last_i) ? ST_IDLE : ST_WAIT_REQ;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state_o     = state_q;
        busy_o      = (state_q != ST_IDLE);
        load_o      = (state_q == ST_IDLE) && start_i;
        rd_valid_o  = (state_q == ST_RD_ADDR);
        latch_o     = (state_q == ST_RD_DATA) && rd_resp_valid_i && !rd_resp_err_i;
        rd_fault_o  = (state_q == ST_RD_DATA) && rd_resp_valid_i && rd_resp_err_i;
        wr_valid_o  = (state_q == ST_WR_ADDR);
        step_done_o = (state_q == ST_WR_RESP) && wr_resp_valid_i && !wr_resp_err_i;
        wr_fault_o  = (state_q == ST_WR_RESP) && wr_resp_valid_i && wr_resp_err_i;
    end

    // R8: a read request is held until accepted
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_req_ready_i) |=> rd_valid_o);

    // R8: a write request is held until accepted
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_req_ready_i) |=> wr_valid_o);

    // R2: the two master ports never request together
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid_o && wr_valid_o));

    // R11: any error response ends the sequence
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fault_o || wr_fault_o) |=> !busy_o);

endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
    import dma_xfer_pkg::*;
#(
    parameter int NREQ  = 8,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_waddr_i,
    input  logic [31:0]       cfg_wdata_i,
    input  logic [1:0]        cfg_raddr_i,
    output logic [31:0]       cfg_rdata_o,
    input  logic              start_i,
    input  logic [NREQ-1:0]   dreq_i,
    output logic              busy_o,
    output logic              rd_req_valid_o,
    input  logic              rd_req_ready_i,
    output logic [31:0]       rd_req_addr_o,
    output logic [1:0]        rd_req_size_o,
    input  logic              rd_resp_valid_i,
    input  logic [31:0]       rd_resp_data_i,
    input  logic              rd_resp_err_i,
    output logic              wr_req_valid_o,
    input  logic              wr_req_ready_i,
    output logic [31:0]       wr_req_addr_o,
    output logic [31:0]       wr_req_data_o,
    output logic [3:0]        wr_req_strb_o,
    input  logic              wr_resp_valid_i,
    input  logic              wr_resp_err_i
);

    localparam int PAD_W = DATA_W - 4 - CTRL_W;

    chan_ctrl_t        ctrl_q;
    logic              rd_err_q, wr_err_q;
    logic [ADDR_W-1:0] ra_q, wa_q, ra_next, wa_next;
    logic [CNT_W-1:0]  reload_q, remain_q;
    logic [DATA_W-1:0] data_q;

    chan_state_e state;
    logic start_ok, go, req_hit, unpaced;
    logic load, latch, rd_fault, wr_fault, step_done;
    logic wr_ctrl, wr_ra, wr_wa, wr_cnt;

    assign wr_ctrl = cfg_we_i && (cfg_waddr_i == REG_CTRL);
    assign wr_ra   = cfg_we_i && (cfg_waddr_i == REG_RADDR);
    assign wr_wa   = cfg_we_i && (cfg_waddr_i == REG_WADDR);
    assign wr_cnt  = cfg_we_i && (cfg_waddr_i == REG_COUNT);

    // R12: a zero reload never starts a sequence
    assign start_ok = start_i && (reload_q != '0);

    // R9: request-line select, all-ones select runs unpaced
    assign unpaced = (ctrl_q.req_sel == SEL_FREE);
    always_comb begin
        req_hit = 1'b0;
        for (int k = 0; k < NREQ; k++) begin
            if (ctrl_q.req_sel == SEL_W'(k)) req_hit = dreq_i[k];
        end
    end

    // R10: enable gates every item start
    assign go = ctrl_q.en && (unpaced || req_hit);

    dma_chan_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_ok),
        .go_i            (go),
        .last_i          (remain_q == CNT_W'(1)),
        .rd_req_ready_i  (rd_req_ready_i),
        .rd_resp_valid_i (rd_resp_valid_i),
        .rd_resp_err_i   (rd_resp_err_i),
        .wr_req_ready_i  (wr_req_ready_i),
        .wr_resp_valid_i (wr_resp_valid_i),
        .wr_resp_err_i   (wr_resp_err_i),
        .state_o         (state),
        .busy_o          (busy_o),
        .load_o          (load),
        .rd_valid_o      (rd_req_valid_o),
        .latch_o         (latch),
        .rd_fault_o      (rd_fault),
        .wr_valid_o      (wr_req_valid_o),
        .step_done_o     (step_done),
        .wr_fault_o      (wr_fault)
    );

    // R4 / R5: ring goes to the read side when ring_sel is low
    dma_addr_step u_rd_step (
        .addr_i      (ra_q),
        .size_i      (ctrl_q.size),
        .inc_i       (ctrl_q.inc_rd),
        .ring_on_i   (!ctrl_q.ring_sel),
        .ring_bits_i (ctrl_q.ring_bits),
        .addr_o      (ra_next)
    );

    dma_addr_step u_wr_step (
        .addr_i      (wa_q),
        .size_i      (ctrl_q.size),
        .inc_i       (ctrl_q.inc_wr),
        .ring_on_i   (ctrl_q.ring_sel),
        .ring_bits_i (ctrl_q.ring_bits),
        .addr_o      (wa_next)
    );

    dma_lane_pack u_lanes (
        .rd_word_i (data_q),
        .rd_off_i  (ra_q[1:0]),
        .wr_off_i  (wa_q[1:0]),
        .size_i    (ctrl_q.size),
        .bswap_i   (ctrl_q.bswap),
        .wr_data_o (wr_req_data_o),
        .wr_strb_o (wr_req_strb_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RESET;
            rd_err_q <= 1'b0;
            wr_err_q <= 1'b0;
            ra_q     <= '0;
            wa_q     <= '0;
            reload_q <= '0;
            remain_q <= '0;
            data_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= chan_ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);

            // R11: set on fault wins over a write-one clear
            if (rd_fault) rd_err_q <= 1'b1;
            else if (wr_ctrl && cfg_wdata_i[BIT_RD_ERR]) rd_err_q <= 1'b0;
            if (wr_fault) wr_err_q <= 1'b1;
            else if (wr_ctrl && cfg_wdata_i[BIT_WR_ERR]) wr_err_q <= 1'b0;

            if (wr_ra) ra_q <= cfg_wdata_i;
            else if (step_done) ra_q <= ra_next;
            if (wr_wa) wa_q <= cfg_wdata_i;
            else if (step_done) wa_q <= wa_next;

            // R6: writes land in the reload only
            if (wr_cnt) reload_q <= cfg_wdata_i[CNT_W-1:0];
            if (load) remain_q <= reload_q;
            else if (step_done) remain_q <= remain_q - CNT_W'(1);

            if (latch) data_q <= rd_resp_data_i;
        end
    end

    assign rd_req_addr_o = ra_q;
    assign rd_req_size_o = ctrl_q.size;
    assign wr_req_addr_o = wa_q;

    always_comb begin
        unique case (cfg_raddr_i)
            REG_RADDR: cfg_rdata_o = ra_q;
            REG_WADDR: cfg_rdata_o = wa_q;
            REG_COUNT: cfg_rdata_o = 32'(remain_q);
            default:   cfg_rdata_o = {busy_o, wr_err_q, rd_err_q, rd_err_q | wr_err_q,
                                      {PAD_W{1'b0}}, ctrl_q};
        endcase
    end

    // R9
    pace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_REQ && !unpaced && !req_hit) |=> !rd_req_valid_o);

    // R10
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_REQ && !ctrl_q.en) |=> !rd_req_valid_o);

    // R2
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> (remain_q == $past(remain_q) - CNT_W'(1)));

    // R6
    remain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !step_done) |=> $stable(remain_q));

    // R8
    strb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid_o |-> ($countones(wr_req_strb_o) == int'(step_bytes(ctrl_q.size))));

    // R12
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && reload_q == '0) |=> !busy_o);

endmodule

// File: tb/dma_xfer_chan_tb_top.sv
module dma_xfer_chan_tb_top;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        start = 1'b0;
    logic [7:0]  dreq = '0;
    logic        busy;
    logic        rd_req_valid, rd_req_ready = 1'b1;
    logic [31:0] rd_req_addr;
    logic [1:0]  rd_req_size;
    logic        rd_resp_valid = 1'b0, rd_resp_err = 1'b0;
    logic [31:0] rd_resp_data = '0;
    logic        wr_req_valid, wr_req_ready = 1'b1;
    logic [31:0] wr_req_addr, wr_req_data;
    logic [3:0]  wr_req_strb;
    logic        wr_resp_valid = 1'b0, wr_resp_err = 1'b0;

    int errors = 0;
    int checks = 0;
    int rd_seen = 0;
    int wr_seen = 0;
    bit slow = 1'b0;
    bit inject_rd_err = 1'b0;
    bit inject_wr_err = 1'b0;
    bit rd_pend = 1'b0, wr_pend = 1'b0;
    logic [31:0] rd_pend_addr = '0;
    string cur_tag = "R8";
    wr_item_t exp_q[$];

    always #5 clk = ~clk;

    dma_xfer_chan #(.NREQ(8), .CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_waddr_i(cfg_waddr), .cfg_wdata_i(cfg_wdata),
        .cfg_raddr_i(cfg_raddr), .cfg_rdata_o(cfg_rdata),
        .start_i(start), .dreq_i(dreq), .busy_o(busy),
        .rd_req_valid_o(rd_req_valid), .rd_req_ready_i(rd_req_ready),
        .rd_req_addr_o(rd_req_addr), .rd_req_size_o(rd_req_size),
        .rd_resp_valid_i(rd_resp_valid), .rd_resp_data_i(rd_resp_data),
        .rd_resp_err_i(rd_resp_err),
        .wr_req_valid_o(wr_req_valid), .wr_req_ready_i(wr_req_ready),
        .wr_req_addr_o(wr_req_addr), .wr_req_data_o(wr_req_data),
        .wr_req_strb_o(wr_req_strb),
        .wr_resp_valid_i(wr_resp_valid), .wr_resp_err_i(wr_resp_err)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] ^ 8'h5A) + {6'd0, a[9:8]};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = mem_byte({a[31:2], 2'b00} + 32'(k));
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Slave models and scoreboard monitor, all away from the active edge
    always @(negedge clk) begin
        rd_resp_valid = 1'b0;
        rd_resp_err   = 1'b0;
        wr_resp_valid = 1'b0;
        wr_resp_err   = 1'b0;
        if (rd_pend) begin
            rd_resp_valid = 1'b1;
            rd_resp_data  = mem_word(rd_pend_addr);
            rd_resp_err   = inject_rd_err;
            inject_rd_err = 1'b0;
            rd_pend       = 1'b0;
        end
        if (wr_pend) begin
            wr_resp_valid = 1'b1;
            wr_resp_err   = inject_wr_err;
            inject_wr_err = 1'b0;
            wr_pend       = 1'b0;
        end
        rd_req_ready = slow ? ~rd_req_ready : 1'b1;
        wr_req_ready = slow ? ~wr_req_ready : 1'b1;
        if (rd_req_valid && rd_req_ready) begin
            rd_pend = 1'b1;
            rd_pend_addr = rd_req_addr;
            rd_seen++;
        end
        if (wr_req_valid && wr_req_ready) begin
            wr_pend = 1'b1;
            wr_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, {cur_tag, " unexpected write"}, wr_req_addr, 32'h0);
            end else begin
                wr_item_t e;
                logic [31:0] m;
                e = exp_q.pop_front();
                for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{e.strb[k]}};
                chk(wr_req_addr == e.addr, {cur_tag, " write address"}, wr_req_addr, e.addr);
                chk(wr_req_strb == e.strb, {cur_tag, " R8 strobe"}, 32'(wr_req_strb), 32'(e.strb));
                chk((wr_req_data & m) == e.data, {cur_tag, " write data"}, wr_req_data & m, e.data);
            end
        end
    end

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_raddr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input bit en, input logic [1:0] sz, input bit ir, input bit iw,
                                            input logic [3:0] rs, input bit rsel, input bit bsw,
                                            input logic [5:0] sel);
        return {15'd0, sel, bsw, rsel, rs, iw, ir, sz, en};
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] a, input int nb, input bit inc,
                                        input logic [3:0] rs, input bit on);
        logic [31:0] s, m;
        if (!inc) return a;
        s = a + 32'(nb);
        if (on && rs != 0) begin
            m = (32'd1 << rs) - 32'd1;
            return (a & ~m) | (s & m);
        end
        return s;
    endfunction

    // Driver: pushes the expected writes; returns the final addresses
    task automatic push_expected(input logic [31:0] ra, input logic [31:0] wa, input int cnt,
                                 input logic [1:0] sz, input bit ir, input bit iw,
                                 input logic [3:0] rs, input bit rsel, input bit bsw,
                                 output logic [31:0] ra_end, output logic [31:0] wa_end);
        int nb;
        logic [31:0] a, w;
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        a = ra; w = wa;
        for (int i = 0; i < cnt; i++) begin
            wr_item_t e;
            e.addr = w; e.data = '0; e.strb = '0;
            for (int j = 0; j < nb; j++) begin
                int src, lane;
                src  = bsw ? (nb - 1 - j) : j;
                lane = int'(w[1:0]) + j;
                e.data[8*lane +: 8] = mem_byte(a + 32'(src));
                e.strb[lane] = 1'b1;
            end
            exp_q.push_back(e);
            a = adv(a, nb, ir, rs, !rsel);
            w = adv(w, nb, iw, rs, rsel);
        end
        ra_end = a; wa_end = w;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, {tag, " completes before timeout"}, 32'(busy), 32'h0);
    endtask

    task automatic run_seq(input string tag, input logic [31:0] ra, input logic [31:0] wa, input int cnt,
                           input logic [1:0] sz, input bit ir, input bit iw, input logic [3:0] rs,
                           input bit rsel, input bit bsw);
        logic [31:0] ra_end, wa_end, v;
        cur_tag = tag;
        cfg_write(2'd0, ra);
        cfg_write(2'd1, wa);
        cfg_write(2'd2, 32'(cnt));
        cfg_write(2'd3, mk_ctrl(1'b1, sz, ir, iw, rs, rsel, bsw, 6'h3F));
        push_expected(ra, wa, cnt, sz, ir, iw, rs, rsel, bsw, ra_end, wa_end);
        pulse_start();
        chk(busy == 1'b1, "R2 busy rises after start", 32'(busy), 32'h1);
        wait_idle(tag);
        chk(exp_q.size() == 0, {tag, " all writes seen"}, 32'(exp_q.size()), 32'h0);
        cfg_read(2'd0, v);
        chk(v == ra_end, {tag, " final read address"}, v, ra_end);
        cfg_read(2'd1, v);
        chk(v == wa_end, {tag, " final write address"}, v, wa_end);
        cfg_read(2'd2, v);
        chk(v == 32'h0, "R2 remaining count zero at end", v, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] ra_e, wa_e;
        int seen0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cfg_read(2'd3, v);
        chk(v == 32'h0001F81D, "R1 control reset value", v, 32'h0001F81D);
        cfg_read(2'd0, v);
        chk(v == 32'h0, "R1 read address reset", v, 32'h0);
        cfg_read(2'd2, v);
        chk(v == 32'h0, "R1 count reset", v, 32'h0);
        chk(busy == 1'b0, "R1 busy reset", 32'(busy), 32'h0);

        // R2 R3: word copy, then with a toggling ready
        run_seq("R3 word", 32'h100, 32'h200, 4, 2'd2, 1, 1, 4'd0, 0, 0);
        slow = 1'b1;
        run_seq("R2 word slow", 32'h140, 32'h240, 3, 2'd2, 1, 1, 4'd0, 0, 0);
        slow = 1'b0;
        // R3 halfword, fixed read address
        run_seq("R3 half fixed read", 32'h40, 32'h80, 3, 2'd1, 0, 1, 4'd0, 0, 0);
        // R8 bytes on an unaligned, fixed write address
        run_seq("R8 byte lanes", 32'h43, 32'h51, 3, 2'd0, 1, 0, 4'd0, 0, 0);
        // R7 reversal on halfword and word
        run_seq("R7 half swap", 32'h12, 32'h32, 2, 2'd1, 1, 1, 4'd0, 0, 1);
        run_seq("R7 word swap", 32'h20, 32'h60, 2, 2'd2, 1, 1, 4'd0, 0, 1);
        run_seq("R7 byte unchanged", 32'h71, 32'h92, 2, 2'd0, 1, 1, 4'd0, 0, 1);
        // R4 ring on read side, R5 ring on write side
        run_seq("R4 ring read", 32'h100, 32'h300, 4, 2'd2, 1, 1, 4'd3, 0, 0);
        run_seq("R5 ring write", 32'h180, 32'h3F8, 3, 2'd2, 1, 1, 4'd3, 1, 0);

        // R9 pacing on line 2
        cur_tag = "R9 paced";
        cfg_write(2'd0, 32'h200);
        cfg_write(2'd1, 32'h400);
        cfg_write(2'd2, 32'd3);
        cfg_write(2'd3, mk_ctrl(1, 2'd2, 1, 1, 4'd0, 0, 0, 6'd2));
        push_expected(32'h200, 32'h400, 3, 2'd2, 1, 1, 4'd0, 0, 0, ra_e, wa_e);
        seen0 = rd_seen;
        dreq = 8'b1111_1011;
        pulse_start();
        repeat (10) @(negedge clk);
        chk(rd_seen == seen0, "R9 no read while selected line low", 32'(rd_seen - seen0), 32'h0);
        cfg_read(2'd2, v);
        chk(v == 32'd3, "R9 count held while waiting", v, 32'd3);
        dreq = 8'b0000_0100;
        @(negedge clk);
        dreq = 8'b0000_0000;
        repeat (12) @(negedge clk);
        cfg_read(2'd2, v);
        chk(v == 32'd2, "R9 one item per request cycle", v, 32'd2);
        chk(exp_q.size() == 2, "R9 one write per request cycle", 32'(exp_q.size()), 32'd2);
        dreq = 8'b0000_0100;
        wait_idle("R9");
        dreq = 8'b0;
        chk(exp_q.size() == 0, "R9 all writes after release", 32'(exp_q.size()), 32'h0);

        // R10 enable stall, R6 reload write, R12 start while busy
        cur_tag = "R10 stall";
        cfg_write(2'd0, 32'h500);
        cfg_write(2'd1, 32'h600);
        cfg_write(2'd2, 32'd2);
        cfg_write(2'd3, mk_ctrl(0, 2'd2, 1, 1, 4'd0, 0, 0, 6'h3F));
        push_expected(32'h500, 32'h600, 2, 2'd2, 1, 1, 4'd0, 0, 0, ra_e, wa_e);
        seen0 = rd_seen;
        pulse_start();
        chk(busy == 1'b1, "R10 busy while disabled", 32'(busy), 32'h1);
        repeat (8) @(negedge clk);
        chk(rd_seen == seen0, "R10 no read while disabled", 32'(rd_seen - seen0), 32'h0);
        cfg_write(2'd2, 32'd7);
        pulse_start();
        cfg_read(2'd2, v);
        chk(v == 32'd2, "R6 R12 remaining unchanged by reload write and restart", v, 32'd2);
        cfg_read(2'd0, v);
        chk(v == 32'h500, "R10 read address kept while stalled", v, 32'h500);
        cfg_write(2'd3, mk_ctrl(1, 2'd2, 1, 1, 4'd0, 0, 0, 6'h3F));
        wait_idle("R10");
        cfg_read(2'd0, v);
        chk(v == 32'h508, "R10 resumes to final read address", v, 32'h508);
        chk(exp_q.size() == 0, "R10 writes after resume", 32'(exp_q.size()), 32'h0);
        cur_tag = "R6 new total";
        push_expected(32'h508, 32'h608, 7, 2'd2, 1, 1, 4'd0, 0, 0, ra_e, wa_e);
        pulse_start();
        wait_idle("R6");
        chk(exp_q.size() == 0, "R6 next sequence uses new total", 32'(exp_q.size()), 32'h0);

        // R11 read error
        cur_tag = "R11 read error";
        cfg_write(2'd0, 32'h700);
        cfg_write(2'd1, 32'h800);
        cfg_write(2'd2, 32'd3);
        seen0 = wr_seen;
        inject_rd_err = 1'b1;
        pulse_start();
        wait_idle("R11");
        chk(wr_seen == seen0, "R11 no write after read error", 32'(wr_seen - seen0), 32'h0);
        cfg_read(2'd3, v);
        chk(v[31:28] == 4'b0011, "R11 read error flag and OR", 32'(v[31:28]), 32'h3);
        cfg_read(2'd2, v);
        chk(v == 32'd3, "R11 count not stepped on read error", v, 32'd3);
        cfg_read(2'd0, v);
        chk(v == 32'h700, "R11 read address not stepped", v, 32'h700);
        cfg_write(2'd3, 32'h0001F81D | (32'd1 << 29));
        cfg_read(2'd3, v);
        chk(v[31:28] == 4'b0000, "R11 write-one clears read error", 32'(v[31:28]), 32'h0);

        // R11 write error
        cur_tag = "R11 write error";
        push_expected(32'h700, 32'h800, 1, 2'd2, 1, 1, 4'd0, 0, 0, ra_e, wa_e);
        inject_wr_err = 1'b1;
        pulse_start();
        wait_idle("R11");
        chk(exp_q.size() == 0, "R11 the failing write was issued", 32'(exp_q.size()), 32'h0);
        cfg_read(2'd3, v);
        chk(v[31:28] == 4'b0101, "R11 write error flag and OR", 32'(v[31:28]), 32'h5);
        cfg_read(2'd1, v);
        chk(v == 32'h800, "R11 write address not stepped", v, 32'h800);
        cfg_write(2'd3, 32'h0001F81D);
        cfg_read(2'd3, v);
        chk(v[30] == 1'b1, "R11 writing zero keeps write error", 32'(v[30]), 32'h1);
        cfg_write(2'd3, 32'h0001F81D | (32'd1 << 30));
        cfg_read(2'd3, v);
        chk(v[31:28] == 4'b0000, "R11 write-one clears write error", 32'(v[31:28]), 32'h0);

        // R12 zero reload
        cfg_write(2'd2, 32'd0);
        seen0 = rd_seen;
        pulse_start();
        chk(busy == 1'b0, "R12 zero count start ignored", 32'(busy), 32'h0);
        repeat (4) @(negedge clk);
        chk(rd_seen == seen0, "R12 no read after zero count start", 32'(rd_seen - seen0), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule